// File: doc/BRIEF.md
# User RAM Clear Controller

This block wipes a small on-chip user RAM to all ones when an external active-low clear pin falls, provided software has armed it with a clear-enable bit. Once triggered, it drives a write port through every location of the user RAM in ascending order, one write per clock. It then holds host access locked for a fixed number of recovery cycles. At the end of the sweep it sets a completion flag. Software clears the flag by writing zero to it.

The completion flag can also request an interrupt. The request is passed on only when its interrupt-enable bit is set and the main supply is reported good. An input from the other interrupt sources of the surrounding chip is merged with this request into one active-low interrupt line. The sweep itself runs whether or not main supply is present. The block touches nothing but the user RAM write port.

Top module: `ramclr_top`

## Requirements
- R1: A triggered clear writes data with every bit set to 1 to each address from 0 to DEPTH-1. The writes go in ascending order, one per clock cycle, DEPTH writes in total and no more.
- R2: A clear is triggered by a high-to-low transition of `clr_n_i` once it has passed a synchroniser of SYNC_STAGES flops. `rce_i` must be 1 when that transition is detected. A pin held low, or a rising transition, triggers nothing.
- R3: With `rce_i` at 0, a falling transition on `clr_n_i` produces no RAM write and leaves `flag_o` unchanged.
- R4: `flag_o` rises in the cycle after the last write of a sweep. It stays high until it is cleared.
- R5: While `flag_o`, `rie_i` and `vcc_ok_i` are all 1, `irq_n_o` is 0. If either `rie_i` or `vcc_ok_i` is 0, the flag alone does not drive `irq_n_o` low.
- R6: A one-cycle pulse on `flag_clr_i` clears `flag_o` on the next edge. If a set and a clear fall in the same cycle, the set wins. `irq_n_o` is 1 when no request from this block is present and `other_irq_i` is 0. `other_irq_i` at 1 drives `irq_n_o` low on its own.
- R7: `lock_o` is high from the first write through REC_CYCLES cycles after the last write, which is DEPTH+REC_CYCLES cycles in all. The RAM is written only while `lock_o` is high.
- R8: A falling transition on `clr_n_i` while a sweep or its recovery period is in progress is ignored. It starts no second sweep.
- R9: The sweep runs in full with `vcc_ok_i` at 0.
- R10: After reset, `ram_we_o`, `lock_o` and `flag_o` are 0 and `irq_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n_i | input | 1 | Asynchronous active-low clear pin |
| rce_i | input | 1 | Clear enable |
| rie_i | input | 1 | Completion interrupt enable |
| vcc_ok_i | input | 1 | Main supply present |
| flag_clr_i | input | 1 | Write-zero strobe for the completion flag |
| other_irq_i | input | 1 | Other interrupt sources pending |
| ram_we_o | output | 1 | User RAM write enable |
| ram_addr_o | output | ADDR_W | User RAM write address |
| ram_wdata_o | output | DATA_W | User RAM write data (all ones) |
| flag_o | output | 1 | Completion flag |
| irq_n_o | output | 1 | Combined active-low interrupt |
| lock_o | output | 1 | Host access lockout |

## Verification
The bench keeps the full user RAM depth of 114 bytes and the default two-stage synchroniser. This makes the complete address sweep, including its last address, part of every run. The recovery period is cut to 6 cycles so the bench can time the lockout exactly. It also lets the bench place a second falling edge inside the recovery window as well as inside the sweep. A scoreboard compares every write against the expected ascending all-ones sequence, so a missing, extra or reordered write shows up.

// File: rtl/ramclr_pkg.sv
// Package: shared types for the user RAM clear controller.
// Assumes nothing beyond a single clock domain for its users.
package ramclr_pkg;
    // Sequencer phases: waiting, sweeping the RAM, holding the lockout.
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_SWEEP   = 2'd1,
        PH_RECOVER = 2'd2
    } phase_t;
endpackage

// File: rtl/ramclr_edge.sv
// Module: ramclr_edge
// Brings the asynchronous active-low clear pin into the clock domain through
// SYNC_STAGES flops and flags a high-to-low transition for one cycle.
// Assumes the pin stays at each level for at least two clock cycles.
module ramclr_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n_i,
    output logic fall_o
);
    // chain[0..SYNC_STAGES-1] synchronise, chain[SYNC_STAGES] holds the prior level
    logic [SYNC_STAGES:0] chain;

    for (genvar i = 0; i <= SYNC_STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // Capture the raw pin; reset to the idle (high) level.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b1;
                else        chain[i] <= pin_n_i;
            end
        end else begin : g_next
            // Shift the sampled level one stage further.
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b1;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    assign fall_o = chain[SYNC_STAGES] & ~chain[SYNC_STAGES-1];
endmodule

// File: rtl/ramclr_seq.sv
// Module: ramclr_seq
// Walks the write port over addresses 0..DEPTH-1 once per start, then holds a
// lockout for REC_CYCLES cycles. Starts arriving while busy are dropped.
// Assumes start_i is a single-cycle pulse already gated by the enable bit.
module ramclr_seq
    import ramclr_pkg::*;
#(
    parameter int DEPTH      = 114,
    parameter int REC_CYCLES = 16,
    parameter int ADDR_W     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              done_o,
    output logic              lock_o
);
    localparam int CNT_W = (REC_CYCLES > 1) ? $clog2(REC_CYCLES) : 1;
    localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0]  LAST_REC  = CNT_W'((REC_CYCLES > 0) ? REC_CYCLES - 1 : 0);

    phase_t            phase, phase_nx;
    logic [ADDR_W-1:0] addr_q;
    logic [CNT_W-1:0]  rec_q;
    logic              last_wr;

    assign last_wr = (phase == PH_SWEEP) && (addr_q == LAST_ADDR);

    // Pick the next phase; the recovery phase is skipped when REC_CYCLES is 0.
    always_comb begin
        phase_nx = phase;
        case (phase)
            PH_IDLE:    if (start_i) phase_nx = PH_SWEEP;
            PH_SWEEP:   if (last_wr) phase_nx = (REC_CYCLES > 0) ? PH_RECOVER : PH_IDLE;
            PH_RECOVER: if (rec_q == LAST_REC) phase_nx = PH_IDLE;
            default:    phase_nx = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    // Address counter: restarts at 0 on a start, steps during the sweep.
    always_ff @(posedge clk) begin
        if (!rst_n)                            addr_q <= '0;
        else if (phase == PH_IDLE)             addr_q <= '0;
        else if (phase == PH_SWEEP && !last_wr) addr_q <= addr_q + 1'b1;
    end

    // Recovery counter: counts cycles spent in the recovery phase.
    always_ff @(posedge clk) begin
        if (!rst_n)                  rec_q <= '0;
        else if (phase == PH_RECOVER) rec_q <= rec_q + 1'b1;
        else                          rec_q <= '0;
    end

    assign we_o   = (phase == PH_SWEEP);
    assign addr_o = addr_q;
    assign done_o = last_wr;
    assign lock_o = (phase != PH_IDLE);
endmodule

// File: rtl/ramclr_flag.sv
// Module: ramclr_flag
// Holds the completion flag (set by the sequencer, cleared by a write-zero
// strobe, set wins) and forms the combined active-low interrupt line.
// Assumes the interrupt is only reported while main supply is good.
module ramclr_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic rie_i,
    input  logic vcc_ok_i,
    input  logic other_irq_i,
    output logic flag_o,
    output logic irq_n_o
);
    logic flag_q;

    // Completion flag: set has priority over the software clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_q <= 1'b0;
        else if (set_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end

    assign flag_o  = flag_q;
    assign irq_n_o = ~((flag_q & rie_i & vcc_ok_i) | other_irq_i);
endmodule

// File: rtl/ramclr_top.sv
// Module: ramclr_top
// User RAM clear controller: on an enabled falling edge of the clear pin it
// fills the user RAM with ones, reports completion, and locks host access.
// Assumes the RAM accepts one write per cycle and that clk runs whenever a
// clear may be requested, with or without main supply.
module ramclr_top #(
    parameter int DEPTH       = 114,
    parameter int DATA_W      = 8,
    parameter int REC_CYCLES  = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n_i,
    input  logic              rce_i,
    input  logic              rie_i,
    input  logic              vcc_ok_i,
    input  logic              flag_clr_i,
    input  logic              other_irq_i,
    output logic              ram_we_o,
    output logic [ADDR_W-1:0] ram_addr_o,
    output logic [DATA_W-1:0] ram_wdata_o,
    output logic              flag_o,
    output logic              irq_n_o,
    output logic              lock_o
);
    logic pin_fall;
    logic sweep_done;

    ramclr_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .pin_n_i (clr_n_i),
        .fall_o  (pin_fall)
    );

    ramclr_seq #(.DEPTH(DEPTH), .REC_CYCLES(REC_CYCLES), .ADDR_W(ADDR_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (pin_fall & rce_i),
        .we_o    (ram_we_o),
        .addr_o  (ram_addr_o),
        .done_o  (sweep_done),
        .lock_o  (lock_o)
    );

    ramclr_flag u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_i       (sweep_done),
        .clr_i       (flag_clr_i),
        .rie_i       (rie_i),
        .vcc_ok_i    (vcc_ok_i),
        .other_irq_i (other_irq_i),
        .flag_o      (flag_o),
        .irq_n_o     (irq_n_o)
    );

    assign ram_wdata_o = '1;
endmodule

// File: rtl/ramclr_checker.sv
// Module: ramclr_checker
// Property checks on the ports of ramclr_top, attached by bind below.
// Assumes the same parameters as the instance it is bound to.
module ramclr_checker #(
    parameter int DEPTH  = 114,
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rie_i,
    input logic              vcc_ok_i,
    input logic              flag_clr_i,
    input logic              other_irq_i,
    input logic              ram_we_o,
    input logic [ADDR_W-1:0] ram_addr_o,
    input logic [DATA_W-1:0] ram_wdata_o,
    input logic              flag_o,
    input logic              irq_n_o,
    input logic              lock_o
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    AST_WRITE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> (ram_wdata_o == {DATA_W{1'b1}}));                          // R1
    AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> (ram_addr_o <= LAST));                                    // R1
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we_o && $past(ram_we_o) && $past(rst_n)) |-> (ram_addr_o == $past(ram_addr_o) + 1'b1)); // R1
    AST_WRITE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> lock_o);                                                  // R7
    AST_FLAG_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we_o && ram_addr_o == LAST) |=> flag_o);                          // R4
    AST_IRQ_ASSERTED: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && rie_i && vcc_ok_i) |-> !irq_n_o);                           // R5
    AST_FLAG_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !(ram_we_o && ram_addr_o == LAST)) |=> !flag_o);        // R6
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_o && !other_irq_i) |-> irq_n_o);                                // R6
endmodule

bind ramclr_top ramclr_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .rie_i       (rie_i),
    .vcc_ok_i    (vcc_ok_i),
    .flag_clr_i  (flag_clr_i),
    .other_irq_i (other_irq_i),
    .ram_we_o    (ram_we_o),
    .ram_addr_o  (ram_addr_o),
    .ram_wdata_o (ram_wdata_o),
    .flag_o      (flag_o),
    .irq_n_o     (irq_n_o),
    .lock_o      (lock_o)
);

// File: tb/ramclr_top_bench.sv
// Bench: ramclr_top_bench
// Scoreboard bench. The driver pushes expected writes into a queue and the
// monitor pops and compares each write the design makes.
module ramclr_top_bench;
    localparam int DEPTH  = 114;
    localparam int DATA_W = 8;
    localparam int REC    = 6;
    localparam int ADDR_W = $clog2(DEPTH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic clr_n = 1'b1, rce = 1'b0, rie = 1'b0, vcc_ok = 1'b1, fclr = 1'b0, oirq = 1'b0;
    logic we, flag, irq_n, lock;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;

    int n_chk = 0, n_fail = 0;
    int n_wr = 0, n_lock = 0, n_cyc = 0;
    int n_bad = 0;
    logic [ADDR_W-1:0] exp_q[$];

    always #10 clk = ~clk;  // 50 MHz

    ramclr_top #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REC_CYCLES(REC), .SYNC_STAGES(2)) u_ramclr_top (
        .clk(clk), .rst_n(rst_n), .clr_n_i(clr_n), .rce_i(rce), .rie_i(rie),
        .vcc_ok_i(vcc_ok), .flag_clr_i(fclr), .other_irq_i(oirq),
        .ram_we_o(we), .ram_addr_o(addr), .ram_wdata_o(wdata),
        .flag_o(flag), .irq_n_o(irq_n), .lock_o(lock)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: compare every write against the scoreboard queue.
    always @(negedge clk) begin
        if (lock) n_lock++;
        if (we) begin
            n_wr++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL R8: unexpected write at address %0d expected none", addr);
            end else begin
                logic [ADDR_W-1:0] e;
                e = exp_q.pop_front();
                if (addr != e || wdata != {DATA_W{1'b1}}) begin
                    n_bad++;
                    $display("FAIL R1: write addr %0d data %0h expected addr %0d data ff", addr, wdata, e);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 150000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual %0d expected below 150000", n_cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic push_sweep();
        for (int i = 0; i < DEPTH; i++) exp_q.push_back(ADDR_W'(i));
    endtask

    // Driver: one falling pulse on the pin, held low for three cycles.
    task automatic pulse_pin();
        @(negedge clk) clr_n = 1'b0;
        repeat (3) @(negedge clk);
        clr_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int w0, b0;
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(!we && !lock && !flag && irq_n, "R10", {we, lock, flag, irq_n}, 1);

        // R3: disabled clear does nothing
        w0 = n_wr; rce = 1'b0;
        pulse_pin(); idle(DEPTH + REC + 10);
        chk(n_wr == w0, "R3 writes", n_wr - w0, 0);
        chk(!flag && !lock, "R3 flag", flag, 0);

        // R2: held low then rising edge triggers nothing even with enable
        rce = 1'b1; w0 = n_wr;
        @(negedge clk) clr_n = 1'b0;
        rce = 1'b0; idle(5); rce = 1'b1; idle(5);
        clr_n = 1'b1; idle(10);
        chk(n_wr == w0 && !lock, "R2 no trigger", n_wr - w0, 0);

        // R1, R4, R7: enabled clear
        rie = 1'b1; vcc_ok = 1'b1; w0 = n_wr; b0 = n_bad; n_lock = 0;
        push_sweep();
        pulse_pin(); idle(DEPTH + REC + 10);
        chk(n_wr - w0 == DEPTH, "R1 write count", n_wr - w0, DEPTH);
        chk(n_bad == b0 && exp_q.size() == 0, "R1 order", n_bad - b0, 0);
        chk(flag, "R4 flag set", flag, 1);
        chk(n_lock == DEPTH + REC, "R7 lock cycles", n_lock, DEPTH + REC);
        chk(!irq_n, "R5 irq low", irq_n, 0);

        // R5: gating by supply and enable
        @(negedge clk) vcc_ok = 1'b0;
        #1 chk(irq_n, "R5 no supply", irq_n, 1);
        @(negedge clk) vcc_ok = 1'b1; rie = 1'b0;
        #1 chk(irq_n && flag, "R5 rie off", irq_n, 1);
        @(negedge clk) rie = 1'b1;

        // R6: write-zero clears the flag and the interrupt
        @(negedge clk) fclr = 1'b1;
        @(negedge clk) fclr = 1'b0;
        chk(!flag, "R6 flag cleared", flag, 0);
        chk(irq_n, "R6 irq released", irq_n, 1);
        oirq = 1'b1;
        #1 chk(!irq_n, "R6 other source", irq_n, 0);
        @(negedge clk) oirq = 1'b0;

        // R8: edges during sweep and recovery are ignored
        w0 = n_wr; b0 = n_bad; n_lock = 0;
        push_sweep();
        pulse_pin();
        idle(20);
        pulse_pin();                       // inside the sweep
        while (we) @(negedge clk);
        @(negedge clk) clr_n = 1'b0;       // inside recovery
        @(negedge clk); @(negedge clk);
        clr_n = 1'b1;
        idle(DEPTH + REC + 10);
        chk(n_wr - w0 == DEPTH && n_bad == b0, "R8 single sweep", n_wr - w0, DEPTH);
        chk(n_lock == DEPTH + REC, "R8 lock cycles", n_lock, DEPTH + REC);

        // R6: set wins over a simultaneous clear; then clear with the strobe
        @(negedge clk) fclr = 1'b1;
        @(negedge clk) fclr = 1'b0;
        w0 = n_wr;
        push_sweep();
        pulse_pin();
        while (!(we && addr == ADDR_W'(DEPTH - 1))) @(negedge clk);
        fclr = 1'b1;
        @(negedge clk) fclr = 1'b0;
        chk(flag, "R6 set wins", flag, 1);
        idle(REC + 5);
        @(negedge clk) fclr = 1'b1;
        @(negedge clk) fclr = 1'b0;

        // R9: sweep runs without main supply; interrupt held off
        vcc_ok = 1'b0; w0 = n_wr; b0 = n_bad;
        push_sweep();
        pulse_pin(); idle(DEPTH + REC + 10);
        chk(n_wr - w0 == DEPTH && n_bad == b0, "R9 sweep no supply", n_wr - w0, DEPTH);
        chk(flag && irq_n, "R9 flag no irq", {flag, irq_n}, 3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule